// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor that runs in seven operating modes. Software names a register by a 4-bit logical index (0 to 15). The physical register behind that index depends on the current mode, so each exception mode gets private copies of some registers without any save or restore code. The block has two combinational read ports and one write port that takes effect at the clock edge. It also holds the current status word and one saved status word for each exception mode.

The current mode is the 5-bit field in bits [4:0] of the current status word. Software changes mode by writing the whole status word. An exception-entry strobe with a target mode does two things in one cycle: it saves the current status word into the target mode's saved status register, and it switches the mode field to the target. A separate output reports whether the current mode is privileged.

All ports are plain register-file ports. Each access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and right after it is released, the current status reads 0x00000013 (Supervisor), `priv` is 1, every general register reads zero and every saved status register reads zero.
- R2: Logical indices 0 to 7 and index 15 (program counter) each name one physical register. A value written under any mode is read back under every other mode.
- R3: Indices 13 and 14 have a separate physical copy for each of FIQ, IRQ, Supervisor, Abort and Undefined. User and System share one copy.
- R4: In FIQ mode, indices 8 to 12 name five private registers. Every other mode reaches one shared set for indices 8 to 12.
- R5: Mode codes are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. Any other code in status bits [4:0] banks as User and is unprivileged.
- R6: `priv` is 1 in every valid mode except User. This includes System.
- R7: Both read ports are combinational. A write to the index being read in the same cycle shows the old value on the read port until the clock edge, and the new value after it.
- R8: The saved status port reads and writes the register of the current mode. In User, System or an invalid mode, a saved status write changes nothing and the read returns zero.
- R9: At the edge where `exc_enter` is high, the current status word is copied into the saved status register of `exc_mode`, and status bits [4:0] become `exc_mode`. Bits [31:5] are kept. A target without a saved status register (User, System or invalid) only changes the mode.
- R10: In a cycle with `exc_enter`, the current status write and the saved status write are both ignored. A general register write in that cycle uses the mode in force before the edge.
- R11: A current status write replaces all 32 bits at the clock edge. The new bits [4:0] select the bank from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_addr | input | 4 | Logical index, read port A |
| ra_data | output | 32 | Read data A, combinational |
| rb_addr | input | 4 | Logical index, read port B |
| rb_data | output | 32 | Read data B, combinational |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | New current status word |
| cpsr_rdata | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status write enable (current mode) |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status of current mode, zero if none |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode for exception entry |
| priv | output | 1 | Current mode is privileged |

## Verification
Read data, saved status read and `priv` are combinational. They are due in the same cycle as the address or the mode that selects them. Every register update (general write, status write, exception entry) appears exactly one clock edge later. The bench drives all inputs just after the falling edge and compares every output 1 ns later, which is still before the rising edge. Its reference model is updated only after that rising edge, so every comparison sees the state from before the edge, including the same-cycle write-then-read case.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

  localparam int MODE_W      = 5;
  localparam int IDX_W       = 4;
  localparam int NUM_BANKS   = 6;
  localparam int NUM_PHYS    = 31;
  localparam int PHYS_W      = $clog2(NUM_PHYS);
  localparam int FIQ_HI_BASE = 13;
  localparam int SL_BASE     = 18;
  localparam int PC_SLOT     = 30;

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // Slot map: 0-7 common low, 8-12 shared high, 13-17 FIQ high,
  // 18-29 sp/lr pairs by bank, 30 program counter.
  function automatic logic [PHYS_W-1:0] phys_idx(input logic [IDX_W-1:0] idx,
                                                 input bank_e bk);
    logic [PHYS_W-1:0] p;
    if (idx < 4'd8)
      p = {1'b0, idx};
    else if (idx == 4'd15)
      p = PHYS_W'(PC_SLOT);
    else if (idx <= 4'd12)
      p = (bk == BK_FIQ) ? PHYS_W'(FIQ_HI_BASE) + PHYS_W'(idx - 4'd8) : {1'b0, idx};
    else
      p = PHYS_W'(SL_BASE) + {1'b0, bk, 1'b0} + PHYS_W'(idx - 4'd13);
    return p;
  endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import rbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              has_saved,
  output logic              priv
);

  always_comb begin
    bank = BK_USR;
    priv = 1'b1;
    unique case (mode)
      MD_FIQ:  bank = BK_FIQ;
      MD_IRQ:  bank = BK_IRQ;
      MD_SVC:  bank = BK_SVC;
      MD_ABT:  bank = BK_ABT;
      MD_UND:  bank = BK_UND;
      MD_SYS:  bank = BK_USR;
      default: priv = 1'b0;
    endcase
    has_saved = (bank != BK_USR);
  end

  // R6 / R3: System is privileged yet banks with User
  always_comb begin
    if (mode == MD_SYS)
      a_r6_system_priv : assert (priv && !has_saved);
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_addr,
  input  logic [IDX_W-1:0]  rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);

  logic [DATA_W-1:0] slots [NUM_PHYS];
  logic [PHYS_W-1:0] w_slot, a_slot, b_slot;

  assign w_slot = phys_idx(waddr, bank);
  assign a_slot = phys_idx(ra_addr, bank);
  assign b_slot = phys_idx(rb_addr, bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) slots[i] <= '0;
    end else if (we) begin
      slots[w_slot] <= wdata;
    end
  end

  assign ra_data = slots[a_slot];
  assign rb_data = slots[b_slot];

  // R7: a write lands in the slot chosen by the pre-edge bank
  a_r7_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slots[$past(w_slot)] == $past(wdata));

endmodule

// File: rtl/psr_store.sv
module psr_store
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  bank_e             tgt_bank,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  input  logic              exc_enter,
  input  logic [MODE_W-1:0] exc_mode,
  output logic [DATA_W-1:0] cpsr_q,
  output logic [DATA_W-1:0] spsr_rdata
);

  localparam logic [DATA_W-1:0] CPSR_RST = DATA_W'(MD_SVC);

  logic [DATA_W-1:0] saved [NUM_BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cpsr_q <= CPSR_RST;
    else if (exc_enter)
      cpsr_q <= {cpsr_q[DATA_W-1:MODE_W], exc_mode};
    else if (cpsr_we)
      cpsr_q <= cpsr_wdata;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_saved
    if (g == 0) begin : g_none
      assign saved[g] = '0;
    end else begin : g_reg
      logic take_exc, take_sw;
      assign take_exc = exc_enter && (tgt_bank == bank_e'(g));
      assign take_sw  = !exc_enter && spsr_we && (cur_bank == bank_e'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        saved[g] <= '0;
        else if (take_exc) saved[g] <= cpsr_q;
        else if (take_sw)  saved[g] <= spsr_wdata;
      end

      // R9: entry copies the pre-edge status word
      a_r9_entry_copy : assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && tgt_bank == bank_e'(g)) |=> saved[g] == $past(cpsr_q));
      // R8 / R10: untouched unless its own mode writes it or entry targets it
      a_r8_saved_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_enter && tgt_bank == bank_e'(g)) &&
        !(spsr_we && !exc_enter && cur_bank == bank_e'(g)) |=> $stable(saved[g]));
    end
  end

  assign spsr_rdata = saved[cur_bank];

  // R1: reset leaves Supervisor mode
  a_r1_reset_svc : assert property (@(posedge clk)
    !rst_n |=> cpsr_q[MODE_W-1:0] == MD_SVC);
  // R9: mode field follows the target, upper bits kept
  a_r9_mode_switch : assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> cpsr_q[MODE_W-1:0] == $past(exc_mode) &&
                  cpsr_q[DATA_W-1:MODE_W] == $past(cpsr_q[DATA_W-1:MODE_W]));
  // R11: status write when no entry
  a_r11_status_write : assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_we && !exc_enter) |=> cpsr_q == $past(cpsr_wdata));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_rdata,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_rdata,
  input  logic              exc_enter,
  input  logic [4:0]        exc_mode,
  output logic              priv
);

  bank_e cur_bank, tgt_bank;
  logic  cur_saved, tgt_saved, tgt_priv;

  mode_decode u_cur_dec (
    .mode      (cpsr_rdata[MODE_W-1:0]),
    .bank      (cur_bank),
    .has_saved (cur_saved),
    .priv      (priv)
  );

  mode_decode u_tgt_dec (
    .mode      (exc_mode),
    .bank      (tgt_bank),
    .has_saved (tgt_saved),
    .priv      (tgt_priv)
  );

  gpr_bank #(.DATA_W(DATA_W)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (cur_bank),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .ra_addr (ra_addr),
    .rb_addr (rb_addr),
    .ra_data (ra_data),
    .rb_data (rb_data)
  );

  psr_store #(.DATA_W(DATA_W)) u_psr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_bank   (cur_bank),
    .tgt_bank   (tgt_bank),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .exc_enter  (exc_enter),
    .exc_mode   (exc_mode),
    .cpsr_q     (cpsr_rdata),
    .spsr_rdata (spsr_rdata)
  );

  // R8: modes without a saved register read zero
  a_r8_no_saved_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !cur_saved |-> spsr_rdata == '0);
  // R5: an unprivileged target never owns a saved register
  a_r5_target_user : assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_priv |-> !tgt_saved);

endmodule

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ra_addr, rb_addr, wr_addr;
  logic [31:0] ra_data, rb_data, wr_data;
  logic        wr_en, cpsr_we, spsr_we, exc_enter, priv;
  logic [31:0] cpsr_wdata, cpsr_rdata, spsr_wdata, spsr_rdata;
  logic [4:0]  exc_mode;

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00101;

  // reference model
  logic [31:0] m_lo [8];
  logic [31:0] m_uhi [5];
  logic [31:0] m_fhi [5];
  logic [31:0] m_sl [6][2];
  logic [31:0] m_sp [6];
  logic [31:0] m_pc, m_cpsr;

  always #2 clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
    .exc_enter(exc_enter), .exc_mode(exc_mode), .priv(priv)
  );

  function automatic int bk(input logic [4:0] m);
    case (m)
      FIQ: return 1;
      IRQ: return 2;
      SVC: return 3;
      ABT: return 4;
      UND: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_priv(input logic [4:0] m);
    return (m == SYS) || (bk(m) != 0);
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] i, input logic [4:0] m);
    int b = bk(m);
    if (i < 8)   return m_lo[i];
    if (i == 15) return m_pc;
    if (i < 13)  return (b == 1) ? m_fhi[i-8] : m_uhi[i-8];
    return m_sl[b][i-13];
  endfunction

  function automatic logic [4:0] pick_mode(input int unsigned r);
    case (r % 8)
      0: return USR; 1: return FIQ; 2: return IRQ; 3: return SVC;
      4: return ABT; 5: return UND; 6: return SYS; default: return BAD;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "ra_data", ra_data, mread(ra_addr, m_cpsr[4:0]));
    chk(cur_req, "rb_data", rb_data, mread(rb_addr, m_cpsr[4:0]));
    chk(cur_req, "cpsr", cpsr_rdata, m_cpsr);
    chk(cur_req, "spsr", spsr_rdata, m_sp[bk(m_cpsr[4:0])]);
    chk(cur_req, "priv", {31'd0, priv}, {31'd0, exp_priv(m_cpsr[4:0])});
  endtask

  task automatic model_update();
    int b = bk(m_cpsr[4:0]);
    if (wr_en) begin
      if (wr_addr < 8)        m_lo[wr_addr] = wr_data;
      else if (wr_addr == 15) m_pc = wr_data;
      else if (wr_addr < 13) begin
        if (b == 1) m_fhi[wr_addr-8] = wr_data;
        else        m_uhi[wr_addr-8] = wr_data;
      end else m_sl[b][wr_addr-13] = wr_data;
    end
    if (exc_enter) begin
      if (bk(exc_mode) != 0) m_sp[bk(exc_mode)] = m_cpsr;
      m_cpsr = {m_cpsr[31:5], exc_mode};
    end else begin
      if (spsr_we && b != 0) m_sp[b] = spsr_wdata;
      if (cpsr_we) m_cpsr = cpsr_wdata;
    end
  endtask

  task automatic cycle();
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; cpsr_we = 0; spsr_we = 0; exc_enter = 0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    idle();
    cpsr_we = 1; cpsr_wdata = {m_cpsr[31:5], m};
    cycle();
    idle();
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] v);
    idle();
    wr_en = 1; wr_addr = i; wr_data = v;
    cycle();
    idle();
  endtask

  task automatic rd_check(input string req, input logic [3:0] i, input logic [31:0] exp);
    idle();
    ra_addr = i;
    #1;
    chk(req, "directed read", ra_data, exp);
    cycle();
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [4:0] modes [7];
    void'($urandom(32'd20240611));
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
    for (int i = 0; i < 8; i++) m_lo[i] = '0;
    for (int i = 0; i < 5; i++) begin m_uhi[i] = '0; m_fhi[i] = '0; end
    for (int i = 0; i < 6; i++) begin m_sl[i][0] = '0; m_sl[i][1] = '0; m_sp[i] = '0; end
    m_pc = '0; m_cpsr = 32'h13;
    rst_n = 0; idle();
    ra_addr = 0; rb_addr = 0; wr_addr = 0; wr_data = 0;
    cpsr_wdata = 0; spsr_wdata = 0; exc_mode = USR;
    repeat (3) @(posedge clk);
    #1;
    // R1: state while reset is held
    chk("R1", "cpsr in reset", cpsr_rdata, 32'h13);
    chk("R1", "priv in reset", {31'd0, priv}, 32'd1);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    for (int i = 0; i < 16; i++) begin ra_addr = 4'(i); rb_addr = 4'(15 - i); cycle(); end

    // R3: distinct r13/r14 in every mode
    cur_req = "R3";
    for (int k = 0; k < 7; k++) begin
      set_mode(modes[k]);
      wr(13, 32'h5000_0000 + k);
      wr(14, 32'h6000_0000 + k);
    end
    for (int k = 0; k < 7; k++) begin
      logic [31:0] e13;
      set_mode(modes[k]);
      e13 = (modes[k] == USR || modes[k] == SYS) ? 32'h5000_0006 : 32'h5000_0000 + k;
      rd_check("R3", 13, e13);
      rd_check("R3", 14, e13 + 32'h1000_0000);
    end

    // R4: FIQ high registers private
    cur_req = "R4";
    set_mode(FIQ); wr(8, 32'hF1F1_0008); wr(12, 32'hF1F1_000C);
    set_mode(USR); wr(8, 32'hAAAA_0008);
    rd_check("R4", 8, 32'hAAAA_0008);
    set_mode(IRQ); rd_check("R4", 8, 32'hAAAA_0008);
    set_mode(FIQ); rd_check("R4", 8, 32'hF1F1_0008); rd_check("R4", 12, 32'hF1F1_000C);

    // R2: shared low registers and pc
    cur_req = "R2";
    set_mode(IRQ); wr(0, 32'h1234_0000); wr(15, 32'h0000_8000);
    set_mode(FIQ); rd_check("R2", 0, 32'h1234_0000); rd_check("R2", 15, 32'h0000_8000);
    set_mode(SYS); rd_check("R2", 15, 32'h0000_8000);

    // R6: System privileged, User not
    cur_req = "R6";
    #1 chk("R6", "system priv", {31'd0, priv}, 32'd1);
    set_mode(USR);
    #1 chk("R6", "user priv", {31'd0, priv}, 32'd0);

    // R5: invalid code banks as User
    cur_req = "R5";
    set_mode(BAD);
    #1 chk("R5", "invalid priv", {31'd0, priv}, 32'd0);
    rd_check("R5", 13, 32'h5000_0006);
    rd_check("R5", 8, 32'hAAAA_0008);

    // R7: same-cycle write and read
    cur_req = "R7";
    set_mode(SVC);
    idle(); wr_en = 1; wr_addr = 5; wr_data = 32'hDEAD_0005; ra_addr = 5;
    #1 chk("R7", "old value before edge", ra_data, 32'h0);
    cycle(); idle();
    #1 chk("R7", "new value after edge", ra_data, 32'hDEAD_0005);

    // R8: saved status per mode, ignored in User/System
    cur_req = "R8";
    set_mode(IRQ);
    idle(); spsr_we = 1; spsr_wdata = 32'h0000_0AB2; cycle(); idle();
    #1 chk("R8", "irq spsr", spsr_rdata, 32'h0000_0AB2);
    set_mode(USR);
    idle(); spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; cycle(); idle();
    #1 chk("R8", "user spsr zero", spsr_rdata, 32'h0);
    set_mode(SYS);
    idle(); spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; cycle(); idle();
    #1 chk("R8", "system spsr zero", spsr_rdata, 32'h0);
    set_mode(IRQ);
    #1 chk("R8", "irq spsr kept", spsr_rdata, 32'h0000_0AB2);

    // R9: exception entry
    cur_req = "R9";
    idle(); cpsr_we = 1; cpsr_wdata = 32'hA000_0013; cycle(); idle();
    exc_enter = 1; exc_mode = ABT; cycle(); idle();
    #1 chk("R9", "mode after entry", cpsr_rdata, 32'hA000_0017);
    chk("R9", "abort saved", spsr_rdata, 32'hA000_0013);
    exc_enter = 1; exc_mode = SYS; cycle(); idle();
    #1 chk("R9", "entry to system", cpsr_rdata, 32'hA000_001F);

    // R10: entry wins over status writes; gpr write uses old mode
    cur_req = "R10";
    set_mode(SVC);
    idle(); exc_enter = 1; exc_mode = UND;
    cpsr_we = 1; cpsr_wdata = 32'h0000_0010;
    spsr_we = 1; spsr_wdata = 32'h5555_5555;
    wr_en = 1; wr_addr = 13; wr_data = 32'h0BAD_0013;
    cycle(); idle();
    #1 chk("R10", "cpsr write dropped", cpsr_rdata, {m_cpsr[31:5], UND});
    chk("R10", "und saved gets status", spsr_rdata, {m_cpsr[31:5], SVC});
    rd_check("R10", 13, 32'h5000_0005);
    set_mode(SVC); rd_check("R10", 13, 32'h0BAD_0013);

    // R11 plus random mix
    cur_req = "R11";
    idle(); cpsr_we = 1; cpsr_wdata = 32'h1234_5671; cycle(); idle();
    #1 chk("R11", "full status write", cpsr_rdata, 32'h1234_5671);
    cur_req = "R2 R3 R4 R7 R8 R9 R10 R11";
    for (int n = 0; n < 4000; n++) begin
      wr_en = 1'($urandom % 2);
      wr_addr = 4'($urandom); wr_data = $urandom;
      ra_addr = 4'($urandom); rb_addr = 4'($urandom);
      cpsr_we = ($urandom % 6) == 0;
      cpsr_wdata = {27'($urandom), pick_mode($urandom)};
      spsr_we = ($urandom % 3) == 0; spsr_wdata = $urandom;
      exc_enter = ($urandom % 10) == 0; exc_mode = pick_mode($urandom);
      cycle();
    end
    idle();
    #1 compare_all();

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule